// File: doc/BRIEF.md
# Maskable Interrupt Cycle Controller

This block adds interrupt-driven I/O to a 16-bit accumulator machine with a 12-bit address space. It keeps four state bits: the interrupt enable, an input-ready flag, an output-ready flag, and a pending-interrupt bit. A device raises a flag with a one-cycle pulse. If interrupts are enabled and either flag is set, the pending bit is armed during an execute step. When the instruction ends, the surrounding control sees the pending bit and runs a three-step interrupt cycle instead of a fetch. In that cycle the block captures the program counter and writes it to a fixed save address. It then loads the program counter with a fixed service entry address, clears the sequence counter, and drops both the enable and the pending bit.

The block also executes the six I/O instructions. The machine's decoder supplies a one-cycle strobe for the I/O class, which is active at execute step 3 of an indirect instruction with opcode 7. It also supplies instruction bits 11 down to 6. In response the block skips on a flag, takes a character, starts an output, or sets or clears the enable. The sequence step is an input; the block never drives the fetch itself.

Top module: `irq_cycle_ctrl`

## Requirements
- R1: After reset `ien`, `fgi`, `fgo` and `icyc` are 0, and `save_wr`, `pc_load`, `sc_clr`, `pc_inc`, `in_ack` and `out_go` are 0 while no instruction strobe is given.
- R2: A pulse on `dev_in_ready` makes `fgi` 1 at the next edge. A pulse on `dev_out_done` does the same for `fgo`.
- R3: Suppose a cycle has `ien`=1, `fgi` or `fgo` at 1, `icyc`=0 and `t_step` of 3 or more. Then `icyc` is 1 after that cycle's edge.
- R4: While `ien`=0 the flags are ignored: `icyc` stays 0 at every step.
- R5: `icyc` never becomes 1 after a cycle whose `t_step` is 0, 1 or 2, so a fetch in progress is not interrupted.
- R6: The skip orders are decoded from `io_op` bit 3 (instruction bit 9, skip on input) and `io_op` bit 2 (instruction bit 8, skip on output). With `io_exec`=1, they drive `pc_inc`=1 in the same cycle exactly when the tested flag is 1.
- R7: In the interrupt cycle, step 0 captures `pc_in`. Step 1 asserts `save_wr` with `save_addr`=0 and `save_data` equal to the captured value. No write happens at step 0.
- R8: At step 2 of the interrupt cycle the block asserts `pc_load` with `pc_value`=1 and asserts `sc_clr`. After that edge, `icyc` and `ien` are 0 while the flags keep their values.
- R9: With `io_exec`=1, `io_op` bit 1 (instruction bit 7) sets `ien` and `io_op` bit 0 (instruction bit 6) clears it.
- R10: With `io_exec`=1, `io_op` bit 5 (instruction bit 11) drives `in_ack` for that cycle and clears `fgi`. `io_op` bit 4 (instruction bit 10) drives `out_go` and clears `fgo`.
- R11: A device pulse in the same cycle as the clearing instruction wins: the flag is 1 afterwards.
- R12: With `io_exec`=0 the `io_op` bits have no effect on `ien`, the flags, `pc_inc`, `in_ack` or `out_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t_step | input | SW (4) | Current sequence counter step |
| io_exec | input | 1 | I/O instruction execute strobe |
| io_op | input | 6 | Instruction bits 11..6 |
| pc_in | input | AW (12) | Current program counter |
| dev_in_ready | input | 1 | Input device has a new character (pulse) |
| dev_out_done | input | 1 | Output device finished (pulse) |
| ien | output | 1 | Interrupt enable |
| fgi | output | 1 | Input-ready flag |
| fgo | output | 1 | Output-ready flag |
| icyc | output | 1 | Interrupt pending / cycle in progress |
| save_wr | output | 1 | Memory write of the return address |
| save_addr | output | AW (12) | Return-address location |
| save_data | output | AW (12) | Saved program counter |
| pc_load | output | 1 | Load program counter with `pc_value` |
| pc_value | output | AW (12) | Service entry address |
| pc_inc | output | 1 | Skip: increment program counter |
| sc_clr | output | 1 | Clear sequence counter |
| in_ack | output | 1 | Transfer input character to accumulator |
| out_go | output | 1 | Transfer accumulator to output device |

## Verification
Arming is the hardest state to reach. The enable must already be 1 when a flag is present and the step is at least 3. The enable itself can only be set by an instruction strobe, and that strobe must not arm the pending bit in the same cycle. The bench therefore resets the block, raises each combination of flags with device pulses, and sets the enable at step 3. It then presents every step value from 0 to 15 in the next cycle. In each case where the pending bit rises, it walks the three-step interrupt cycle and checks the saved address, the branch and the drop of the enable.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IO_OPS = 6;
  // Field order follows instruction bits 11 down to 6.
  typedef struct packed {
    logic inp;
    logic out;
    logic ski;
    logic sko;
    logic ion;
    logic iof;
  } io_cmd_t;
endpackage

// File: rtl/irq_iodec.sv
module irq_iodec
  import irq_pkg::*;
(
  input  logic              io_exec,
  input  logic [IO_OPS-1:0] io_op,
  output io_cmd_t           cmd
);
  logic [IO_OPS-1:0] gated;

  for (genvar i = 0; i < IO_OPS; i++) begin : g_gate
    assign gated[i] = io_exec & io_op[i];
  end

  assign cmd = io_cmd_t'(gated);
endmodule

// File: rtl/irq_flags.sv
module irq_flags
  import irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    dev_in_ready,
  input  logic    dev_out_done,
  input  io_cmd_t cmd,
  input  logic    cyc_end,
  output logic    ien,
  output logic    fgi,
  output logic    fgo
);
  localparam int NFLAG = 2;

  logic [NFLAG-1:0] set_v, clr_v, flag_q, flag_d;
  logic             ien_q, ien_d;

  assign set_v = {dev_out_done, dev_in_ready};
  assign clr_v = {cmd.out, cmd.inp};

  // Device event has priority over the clearing instruction.
  for (genvar k = 0; k < NFLAG; k++) begin : g_flag
    always_comb begin
      flag_d[k] = flag_q[k];
      if (set_v[k])      flag_d[k] = 1'b1;
      else if (clr_v[k]) flag_d[k] = 1'b0;
    end
  end

  always_comb begin
    ien_d = ien_q;
    if (cyc_end)       ien_d = 1'b0;
    else if (cmd.ion)  ien_d = 1'b1;
    else if (cmd.iof)  ien_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      ien_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      ien_q  <= ien_d;
    end
  end

  assign ien = ien_q;
  assign fgi = flag_q[0];
  assign fgo = flag_q[1];
endmodule

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter int AW          = 12,
  parameter int SW          = 4,
  parameter int FETCH_STEPS = 3,
  parameter int SAVE_ADDR   = 0,
  parameter int ENTRY_ADDR  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] t_step,
  input  logic          ien,
  input  logic          fgi,
  input  logic          fgo,
  input  logic [AW-1:0] pc_in,
  output logic          icyc,
  output logic          save_wr,
  output logic [AW-1:0] save_addr,
  output logic [AW-1:0] save_data,
  output logic          pc_load,
  output logic [AW-1:0] pc_value,
  output logic          sc_clr,
  output logic          cyc_end
);
  localparam logic [SW-1:0] EXEC_MIN = SW'(FETCH_STEPS);
  localparam logic [SW-1:0] ST_SAVE  = SW'(0);
  localparam logic [SW-1:0] ST_WRITE = SW'(1);
  localparam logic [SW-1:0] ST_ENTER = SW'(2);

  logic          r_q, r_d;
  logic [AW-1:0] ret_q;
  logic          arm, st_save, st_write, st_enter, ret_en;

  assign arm      = !r_q && ien && (fgi || fgo) && (t_step >= EXEC_MIN);
  assign st_save  = r_q && (t_step == ST_SAVE);
  assign st_write = r_q && (t_step == ST_WRITE);
  assign st_enter = r_q && (t_step == ST_ENTER);
  assign ret_en   = st_save;

  always_comb begin
    r_d = r_q;
    if (arm)           r_d = 1'b1;
    else if (st_enter) r_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r_q <= 1'b0;
    else        r_q <= r_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ret_q <= '0;
    else if (ret_en) ret_q <= pc_in;
  end

  assign icyc      = r_q;
  assign save_wr   = st_write;
  assign save_addr = AW'(SAVE_ADDR);
  assign save_data = ret_q;
  assign pc_load   = st_enter;
  assign pc_value  = AW'(ENTRY_ADDR);
  assign sc_clr    = st_enter;
  assign cyc_end   = st_enter;
endmodule

// File: rtl/irq_cycle_ctrl.sv
module irq_cycle_ctrl
  import irq_pkg::*;
#(
  parameter int AW = 12,
  parameter int SW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SW-1:0]     t_step,
  input  logic              io_exec,
  input  logic [IO_OPS-1:0] io_op,
  input  logic [AW-1:0]     pc_in,
  input  logic              dev_in_ready,
  input  logic              dev_out_done,
  output logic              ien,
  output logic              fgi,
  output logic              fgo,
  output logic              icyc,
  output logic              save_wr,
  output logic [AW-1:0]     save_addr,
  output logic [AW-1:0]     save_data,
  output logic              pc_load,
  output logic [AW-1:0]     pc_value,
  output logic              pc_inc,
  output logic              sc_clr,
  output logic              in_ack,
  output logic              out_go
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  io_cmd_t    cmd;
  logic       cyc_end;

  // Asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  irq_iodec u_dec (
    .io_exec (io_exec),
    .io_op   (io_op),
    .cmd     (cmd)
  );

  irq_flags u_flags (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .dev_in_ready (dev_in_ready),
    .dev_out_done (dev_out_done),
    .cmd          (cmd),
    .cyc_end      (cyc_end),
    .ien          (ien),
    .fgi          (fgi),
    .fgo          (fgo)
  );

  irq_seq #(.AW(AW), .SW(SW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .t_step    (t_step),
    .ien       (ien),
    .fgi       (fgi),
    .fgo       (fgo),
    .pc_in     (pc_in),
    .icyc      (icyc),
    .save_wr   (save_wr),
    .save_addr (save_addr),
    .save_data (save_data),
    .pc_load   (pc_load),
    .pc_value  (pc_value),
    .sc_clr    (sc_clr),
    .cyc_end   (cyc_end)
  );

  assign pc_inc = (cmd.ski & fgi) | (cmd.sko & fgo);
  assign in_ack = cmd.inp;
  assign out_go = cmd.out;
endmodule

// File: rtl/irq_cycle_ctrl_chk.sv
module irq_cycle_ctrl_chk #(
  parameter int AW = 12,
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [SW-1:0] t_step,
  input logic          io_exec,
  input logic [5:0]    io_op,
  input logic [AW-1:0] pc_in,
  input logic          dev_in_ready,
  input logic          dev_out_done,
  input logic          ien,
  input logic          fgi,
  input logic          fgo,
  input logic          icyc,
  input logic          save_wr,
  input logic [AW-1:0] save_data,
  input logic          pc_inc
);
  AST_ARM_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ien && (fgi || fgo) && !icyc && t_step >= SW'(3)) |=> icyc); // R3
  AST_MASKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien && !icyc) |=> !icyc); // R4
  AST_NO_FETCH_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!icyc && t_step < SW'(3)) |=> !icyc); // R5
  AST_SKIP_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (io_exec && io_op[3] && fgi) |-> pc_inc); // R6
  AST_SAVE_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (icyc && t_step == SW'(1) && $past(icyc && t_step == SW'(0)))
      |-> (save_wr && save_data == $past(pc_in))); // R7
  AST_CYCLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (icyc && t_step == SW'(2)) |=> (!icyc && !ien)); // R8
  AST_TAKE_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    (io_exec && io_op[5] && !dev_in_ready) |=> !fgi); // R10
  AST_IN_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    dev_in_ready |=> fgi); // R11
  AST_OUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    dev_out_done |=> fgo); // R2
endmodule

bind irq_cycle_ctrl irq_cycle_ctrl_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .t_step       (t_step),
  .io_exec      (io_exec),
  .io_op        (io_op),
  .pc_in        (pc_in),
  .dev_in_ready (dev_in_ready),
  .dev_out_done (dev_out_done),
  .ien          (ien),
  .fgi          (fgi),
  .fgo          (fgo),
  .icyc         (icyc),
  .save_wr      (save_wr),
  .save_data    (save_data),
  .pc_inc       (pc_inc)
);

// File: tb/irq_cycle_ctrl_test.sv
`timescale 1ns/1ps
module irq_cycle_ctrl_test;
  localparam int AW = 12;
  localparam int SW = 4;
  localparam logic [5:0] OP_INP = 6'b100000, OP_OUT = 6'b010000,
                         OP_SKI = 6'b001000, OP_SKO = 6'b000100,
                         OP_ION = 6'b000010, OP_IOF = 6'b000001;

  logic clk = 1'b0;
  logic rst_n;
  logic [SW-1:0] t_step;
  logic io_exec;
  logic [5:0] io_op;
  logic [AW-1:0] pc_in;
  logic dev_in_ready, dev_out_done;
  logic ien, fgi, fgo, icyc, save_wr, pc_load, pc_inc, sc_clr, in_ack, out_go;
  logic [AW-1:0] save_addr, save_data, pc_value;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_cycle_ctrl #(.AW(AW), .SW(SW)) uut (
    .clk(clk), .rst_n(rst_n), .t_step(t_step), .io_exec(io_exec), .io_op(io_op),
    .pc_in(pc_in), .dev_in_ready(dev_in_ready), .dev_out_done(dev_out_done),
    .ien(ien), .fgi(fgi), .fgo(fgo), .icyc(icyc), .save_wr(save_wr),
    .save_addr(save_addr), .save_data(save_data), .pc_load(pc_load),
    .pc_value(pc_value), .pc_inc(pc_inc), .sc_clr(sc_clr), .in_ack(in_ack),
    .out_go(out_go)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, settle, leave the caller to sample.
  task automatic drive(input int s, input logic ex, input logic [5:0] op,
                       input logic [AW-1:0] pc, input logic inr, input logic outd);
    @(negedge clk);
    t_step = SW'(s); io_exec = ex; io_op = op; pc_in = pc;
    dev_in_ready = inr; dev_out_done = outd;
    #1;
  endtask

  task automatic idle(input int s);
    drive(s, 1'b0, 6'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) idle(4);
    rst_n = 1'b1;
    repeat (3) idle(4);
  endtask

  initial begin
    rst_n = 1'b0; t_step = '0; io_exec = 1'b0; io_op = '0; pc_in = '0;
    dev_in_ready = 1'b0; dev_out_done = 1'b0;
    do_reset();
    // R1
    check({ien, fgi, fgo, icyc}, 4'b0, "R1 state");
    check({save_wr, pc_load, sc_clr, pc_inc, in_ack, out_go}, 6'b0, "R1 strobes");

    // R2: input event
    drive(4, 1'b0, 6'b0, '0, 1'b1, 1'b0);
    idle(4);
    check({fgi, fgo}, 2'b10, "R2 fgi set");
    // R4: masked, every execute step
    for (int s = 3; s < 16; s++) begin
      idle(s);
      check(icyc, 1'b0, "R4 masked");
    end
    // R6: skip on input true, skip on output false
    drive(3, 1'b1, OP_SKI, '0, 1'b0, 1'b0);
    check(pc_inc, 1'b1, "R6 ski fgi=1");
    drive(3, 1'b1, OP_SKO, '0, 1'b0, 1'b0);
    check(pc_inc, 1'b0, "R6 sko fgo=0");
    drive(4, 1'b0, 6'b0, '0, 1'b0, 1'b1);
    idle(4);
    check(fgo, 1'b1, "R2 fgo set");
    drive(3, 1'b1, OP_SKO, '0, 1'b0, 1'b0);
    check(pc_inc, 1'b1, "R6 sko fgo=1");
    // R12: no strobe, no effect
    drive(3, 1'b0, 6'b111111, '0, 1'b0, 1'b0);
    check({pc_inc, in_ack, out_go}, 3'b0, "R12 strobes");
    idle(4);
    check({ien, fgi, fgo}, 3'b011, "R12 state");
    // R10
    drive(3, 1'b1, OP_INP, '0, 1'b0, 1'b0);
    check({in_ack, out_go}, 2'b10, "R10 in_ack");
    drive(3, 1'b1, OP_OUT, '0, 1'b0, 1'b0);
    check(fgi, 1'b0, "R10 fgi cleared");
    check({in_ack, out_go}, 2'b01, "R10 out_go");
    idle(4);
    check(fgo, 1'b0, "R10 fgo cleared");
    // R9
    drive(3, 1'b1, OP_ION, '0, 1'b0, 1'b0);
    idle(4);
    check(ien, 1'b1, "R9 ion");
    drive(3, 1'b1, OP_IOF, '0, 1'b0, 1'b0);
    idle(4);
    check({ien, icyc}, 2'b00, "R9 iof");
    // R11: device wins over clear
    drive(3, 1'b1, OP_INP, '0, 1'b1, 1'b0);
    drive(3, 1'b1, OP_OUT, '0, 1'b0, 1'b1);
    check(fgi, 1'b1, "R11 fgi");
    idle(4);
    check(fgo, 1'b1, "R11 fgo");

    // R3/R5/R7/R8 sweep: flags x step
    for (int f = 0; f < 4; f++) begin
      for (int s = 0; s < 16; s++) begin
        logic exp_arm;
        logic [AW-1:0] pcv;
        exp_arm = (f != 0) && (s >= 3);
        pcv = AW'(12'h200 + f * 16 + s);
        do_reset();
        drive(4, 1'b0, 6'b0, '0, f[0], f[1]);
        drive(3, 1'b1, OP_ION, '0, 1'b0, 1'b0);
        check(icyc, 1'b0, "R3 no arm while ien=0");
        idle(s);
        check(ien, 1'b1, "R9 ion sweep");
        idle(0);
        check(icyc, exp_arm, exp_arm ? "R3 arm" : "R5 no arm");
        if (exp_arm) begin
          drive(0, 1'b0, 6'b0, pcv, 1'b0, 1'b0);
          check({save_wr, pc_load, sc_clr}, 3'b0, "R7 step0 quiet");
          idle(1);
          check(save_wr, 1'b1, "R7 write");
          check(save_addr, 12'd0, "R7 addr");
          check(save_data, pcv, "R7 data");
          idle(2);
          check({pc_load, sc_clr, save_wr}, 3'b110, "R8 load");
          check(pc_value, 12'd1, "R8 entry");
          idle(0);
          check({icyc, ien}, 2'b00, "R8 exit");
          check({fgo, fgi}, f[1:0], "R8 flags kept");
        end
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule